// File: doc/BRIEF.md
# Chainable Dual 16-bit Counter with Coherent Capture

This block holds two 16-bit up/down counters, a lower and an upper channel. Each channel has its own clock-select field and its own capture register. The upper channel can be switched into chained mode, where it stops following a prescaled clock. In that mode it steps once each time the lower counter wraps: up when the lower counter passes from all ones to zero, and down when it passes from zero to all ones. The two counters then behave as a single 32-bit up/down counter.

Each capture register is fed by an input pin. The pin passes through a two-flop synchronizer and a rising-edge detector. On a detected edge, the capture register loads the counter value that was current in that same cycle. When both pins rise together, the two captured halves form a consistent 32-bit snapshot, even if a carry or borrow crosses between the halves in that cycle.

Software reaches every register through a plain 16-bit register port. A write takes effect on every cycle in which the write strobe is high. A read returns data combinationally. Nothing at the block's edge carries a data stream, so the port has no valid/ready pair and never applies back-pressure.

Top module: `casc_cap_timer`

## Requirements
- R1: A synchronous active-high `rst` clears both counters, both capture registers, both start bits and both clock-select fields to zero. The prescaler is also cleared.
- R2: A write stores `bus_wdata` into the register at `bus_addr` on the next edge. The register map is: 0 = start (bit 0 lower, bit 1 upper), 1 = lower select [2:0], 2 = upper select [2:0], 3 = lower count, 4 = upper count, 5 = lower capture, 6 = upper capture. Any other address reads as zero. A write to a counter wins over counting in the same cycle.
- R3: A counter changes only while its own start bit is 1. Both bits must be 1 for chained operation.
- R4: Select codes 0, 1, 2 and 3 step the counter once per 1, 4, 16 and 64 cycles in which `clk_en` is high. Codes 4 to 6 hold the counter, and code 7 also holds the lower counter.
- R5: The lower counter counts down while `count_down` is 1 and up while it is 0. The upper counter always counts up when it uses a prescaled clock.
- R6: With the upper select at 7, a lower wrap from 16'hFFFF to 16'h0000 increments the upper counter.
- R7: With the upper select at 7, a lower wrap from 16'h0000 to 16'hFFFF decrements the upper counter.
- R8: With the upper select at 7, the upper counter does not change in any cycle without a lower wrap.
- R9: A rising edge on a capture pin loads that channel's counter value into its capture register. The update appears on the third clock edge that samples the pin high, and the other channel's capture register is unchanged.
- R10: Rising edges on both pins in the same cycle capture both counters from the same cycle, so the 32-bit snapshot is coherent across a carry.
- R11: While `clk_en` is 0, no prescaled select code advances a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Enable for the internal count clock and prescaler |
| count_down | input | 1 | Lower counter direction, 1 = down |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cap_pin_lo | input | 1 | Capture pin of the lower channel |
| cap_pin_hi | input | 1 | Capture pin of the upper channel |

## Verification
The assertions check several rules on every cycle:
- write priority on the counters;
- holding when a start bit is clear;
- the upper counter stepping by exactly one in the matching direction on each lower wrap, and staying still otherwise in chained mode;
- the counter's step size;
- each capture register taking the counter value of the cycle in which its edge was detected.

Only the bench scenarios can show the exact divide ratios of the prescaler, the end values after long runs in both directions, the capture latency measured from the pin, and the coherence of the 32-bit snapshot as the capture instant is swept across the carry.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;
  localparam int SEL_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_START  = 3'd0,
    A_SEL_LO = 3'd1,
    A_SEL_HI = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_CAP_LO = 3'd5,
    A_CAP_HI = 3'd6
  } reg_addr_e;

  localparam logic [SEL_W-1:0] SEL_CHAIN = 3'b111;
  localparam int NUM_DIV = 4;
endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
  parameter int NUM_DIV = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [NUM_DIV-1:0] ticks
);
  localparam int PRE_W = STEP_LOG2 * (NUM_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (en) pre_q <= pre_q + 1'b1;
  end

  assign ticks[0] = en;
  for (genvar i = 1; i < NUM_DIV; i++) begin : g_div
    assign ticks[i] = en && (&pre_q[STEP_LOG2*i-1:0]);
  end
endmodule

// File: rtl/ctt_edge_sync.sv
module ctt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign rise = chain_q[STAGES-1] && !chain_q[STAGES];
endmodule

// File: rtl/ctt_channel.sv
module ctt_channel #(
  parameter int  CNT_W = 16,
  parameter int  SEL_W = 3,
  parameter int  NUM_DIV = 4,
  parameter bit  CHAIN_EN = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_DIV-1:0] ticks,
  input  logic               chain_up,
  input  logic               chain_dn,
  input  logic               dir_dn,
  input  logic               ld_cnt,
  input  logic               ld_cap,
  input  logic [CNT_W-1:0]   wdata,
  input  logic               cap_evt,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cap,
  output logic               wrap_up,
  output logic               wrap_dn
);
  localparam logic [SEL_W-1:0] SEL_CHAIN = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic up_step, dn_step, tick_sel;

  always_comb begin
    tick_sel = 1'b0;
    if (int'(sel) < NUM_DIV) tick_sel = ticks[sel[1:0]];
  end

  always_comb begin
    up_step = 1'b0;
    dn_step = 1'b0;
    if (run) begin
      if (CHAIN_EN && sel == SEL_CHAIN) begin
        up_step = chain_up;
        dn_step = chain_dn;
      end else begin
        up_step = tick_sel && !dir_dn;
        dn_step = tick_sel && dir_dn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (ld_cnt) cnt <= wdata;
    else if (up_step) cnt <= cnt + 1'b1;
    else if (dn_step) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cap <= '0;
    else if (ld_cap) cap <= wdata;
    else if (cap_evt) cap <= cnt;
  end

  assign wrap_up = up_step && !ld_cnt && (cnt == CNT_MAX);
  assign wrap_dn = dn_step && !ld_cnt && (cnt == '0);
endmodule

// File: rtl/casc_cap_timer.sv
module casc_cap_timer
  import ctt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              count_down,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_pin_lo,
  input  logic              cap_pin_hi
);
  localparam int NCH = 2;

  logic [NCH-1:0]     start_q;
  logic [SEL_W-1:0]   sel_q [NCH];
  logic [CNT_W-1:0]   cnt [NCH];
  logic [CNT_W-1:0]   cap [NCH];
  logic [NCH-1:0]     wrap_up, wrap_dn, rise, pins, ld_cnt, ld_cap;
  logic [NUM_DIV-1:0] ticks;

  assign pins = {cap_pin_hi, cap_pin_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_START:  start_q  <= bus_wdata[NCH-1:0];
        A_SEL_LO: sel_q[0] <= bus_wdata[SEL_W-1:0];
        A_SEL_HI: sel_q[1] <= bus_wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign ld_cnt[0] = bus_we && bus_addr == A_CNT_LO;
  assign ld_cnt[1] = bus_we && bus_addr == A_CNT_HI;
  assign ld_cap[0] = bus_we && bus_addr == A_CAP_LO;
  assign ld_cap[1] = bus_we && bus_addr == A_CAP_HI;

  ctt_prescaler #(.NUM_DIV(NUM_DIV), .STEP_LOG2(2)) u_pre (
    .clk(clk), .rst(rst), .en(clk_en), .ticks(ticks)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ctt_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst(rst), .pin(pins[c]), .rise(rise[c])
    );

    ctt_channel #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .NUM_DIV(NUM_DIV), .CHAIN_EN(c == 1)
    ) u_ch (
      .clk(clk), .rst(rst),
      .run(start_q[c]),
      .sel(sel_q[c]),
      .ticks(ticks),
      .chain_up(c == 1 ? wrap_up[0] : 1'b0),
      .chain_dn(c == 1 ? wrap_dn[0] : 1'b0),
      .dir_dn(c == 0 ? count_down : 1'b0),
      .ld_cnt(ld_cnt[c]),
      .ld_cap(ld_cap[c]),
      .wdata(bus_wdata),
      .cap_evt(rise[c]),
      .cnt(cnt[c]),
      .cap(cap[c]),
      .wrap_up(wrap_up[c]),
      .wrap_dn(wrap_dn[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_START:  bus_rdata = {{(CNT_W-NCH){1'b0}}, start_q};
      A_SEL_LO: bus_rdata = {{(CNT_W-SEL_W){1'b0}}, sel_q[0]};
      A_SEL_HI: bus_rdata = {{(CNT_W-SEL_W){1'b0}}, sel_q[1]};
      A_CNT_LO: bus_rdata = cnt[0];
      A_CNT_HI: bus_rdata = cnt[1];
      A_CAP_LO: bus_rdata = cap[0];
      A_CAP_HI: bus_rdata = cap[1];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/casc_cap_timer_chk.sv
module casc_cap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   start_q,
  input logic [2:0]   sel_hi,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cap_lo,
  input logic [W-1:0] cap_hi,
  input logic [1:0]   ld_cnt,
  input logic [1:0]   ld_cap,
  input logic [1:0]   rise,
  input logic [1:0]   wrap_up,
  input logic [1:0]   wrap_dn,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata
);
  logic chain;
  assign chain = start_q[1] && sel_hi == 3'b111;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && cap_lo == '0 && cap_hi == '0 && start_q == '0));

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd3) |=> cnt_lo == $past(bus_wdata));

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (!start_q[0] && !ld_cnt[0]) |=> $stable(cnt_lo));

  assert_unit_step_R5: assert property (@(posedge clk) disable iff (rst)
    !ld_cnt[0] |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 1'b1
                    || cnt_lo == $past(cnt_lo) - 1'b1));

  assert_carry_up_R6: assert property (@(posedge clk) disable iff (rst)
    (chain && wrap_up[0] && !ld_cnt[1]) |=> cnt_hi == $past(cnt_hi) + 1'b1);

  assert_borrow_dn_R7: assert property (@(posedge clk) disable iff (rst)
    (chain && wrap_dn[0] && !ld_cnt[1]) |=> cnt_hi == $past(cnt_hi) - 1'b1);

  assert_chain_still_R8: assert property (@(posedge clk) disable iff (rst)
    (chain && !wrap_up[0] && !wrap_dn[0] && !ld_cnt[1]) |=> $stable(cnt_hi));

  assert_chain_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    chain |-> ((!wrap_up[1] || wrap_up[0]) && (!wrap_dn[1] || wrap_dn[0])));

  assert_cap_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (rise[0] && !ld_cap[0]) |=> cap_lo == $past(cnt_lo));

  assert_cap_pair_R10: assert property (@(posedge clk) disable iff (rst)
    (rise == 2'b11 && ld_cap == 2'b00) |=>
      (cap_lo == $past(cnt_lo) && cap_hi == $past(cnt_hi)));
endmodule

bind casc_cap_timer casc_cap_timer_chk #(.W(16)) u_chk (
  .clk(clk), .rst(rst), .start_q(start_q), .sel_hi(sel_q[1]),
  .cnt_lo(cnt[0]), .cnt_hi(cnt[1]), .cap_lo(cap[0]), .cap_hi(cap[1]),
  .ld_cnt(ld_cnt), .ld_cap(ld_cap), .rise(rise),
  .wrap_up(wrap_up), .wrap_dn(wrap_dn),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/casc_cap_timer_tb.sv
module casc_cap_timer_tb;
  logic clk = 0, rst = 1, clk_en = 1, count_down = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic cap_pin_lo = 0, cap_pin_hi = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  casc_cap_timer u_dut (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic run64(logic [1:0] st);
    wr(3'd0, {14'd0, st});
    repeat (63) @(negedge clk);
    wr(3'd0, 16'd0);
  endtask

  task automatic t_reset();
    wr(3'd3, 16'h1111); wr(3'd6, 16'h2222); wr(3'd0, 16'h3);
    do_reset();
    for (int a = 0; a < 7; a++) rd_chk("R1 reset", a[2:0], 16'h0);
  endtask

  task automatic t_regs();
    wr(3'd1, 16'h0002); wr(3'd2, 16'h0007);
    wr(3'd3, 16'hA5A5); wr(3'd4, 16'h5A5A);
    wr(3'd5, 16'h1234); wr(3'd6, 16'h4321);
    rd_chk("R2 sel_lo", 3'd1, 16'h2); rd_chk("R2 sel_hi", 3'd2, 16'h7);
    rd_chk("R2 cnt_lo", 3'd3, 16'hA5A5); rd_chk("R2 cnt_hi", 3'd4, 16'h5A5A);
    rd_chk("R2 cap_lo", 3'd5, 16'h1234); rd_chk("R2 cap_hi", 3'd6, 16'h4321);
    rd_chk("R2 unmapped", 3'd7, 16'h0);
    wr(3'd1, 16'h0); wr(3'd0, 16'h1);
    wr(3'd3, 16'h1234);
    wr(3'd0, 16'h0);
    rd_chk("R2 write priority", 3'd3, 16'h1235);
  endtask

  task automatic t_start();
    do_reset();
    wr(3'd3, 16'h0100); wr(3'd4, 16'h0200);
    run64(2'b00);
    rd_chk("R3 none started lo", 3'd3, 16'h0100);
    rd_chk("R3 none started hi", 3'd4, 16'h0200);
    run64(2'b01);
    rd_chk("R3 lo started", 3'd3, 16'h0140);
    rd_chk("R3 hi not started", 3'd4, 16'h0200);
  endtask

  task automatic t_div();
    logic [15:0] exp [4] = '{16'd64, 16'd16, 16'd4, 16'd1};
    for (int s = 0; s < 7; s++) begin
      wr(3'd1, 16'(s)); wr(3'd3, 16'h0);
      run64(2'b01);
      rd_chk($sformatf("R4 sel %0d", s), 3'd3, s < 4 ? exp[s] : 16'h0);
    end
    wr(3'd2, 16'd2); wr(3'd4, 16'h0);
    run64(2'b10);
    rd_chk("R4 hi div16", 3'd4, 16'd4);
    wr(3'd1, 16'd7); wr(3'd3, 16'h0);
    run64(2'b01);
    rd_chk("R4 lo sel7 holds", 3'd3, 16'h0);
  endtask

  task automatic t_noclk();
    wr(3'd1, 16'd0); wr(3'd3, 16'h0050);
    clk_en = 0;
    run64(2'b01);
    clk_en = 1;
    rd_chk("R11 clk_en low", 3'd3, 16'h0050);
  endtask

  task automatic t_down();
    wr(3'd1, 16'd0); wr(3'd2, 16'd0);
    wr(3'd3, 16'd10); wr(3'd4, 16'd0);
    count_down = 1;
    run64(2'b11);
    count_down = 0;
    rd_chk("R5 down through zero", 3'd3, 16'hFFCA);
    rd_chk("R5 upper counts up", 3'd4, 16'd64);
  endtask

  task automatic t_chain();
    wr(3'd1, 16'd0); wr(3'd2, 16'd7);
    wr(3'd3, 16'hFFF0); wr(3'd4, 16'h03A1);
    run64(2'b11);
    rd_chk("R6 lo after carry", 3'd3, 16'h0030);
    rd_chk("R6 hi incremented", 3'd4, 16'h03A2);
    count_down = 1;
    wr(3'd3, 16'h0010);
    run64(2'b11);
    count_down = 0;
    rd_chk("R7 lo after borrow", 3'd3, 16'hFFD0);
    rd_chk("R7 hi decremented", 3'd4, 16'h03A1);
    wr(3'd3, 16'h0000);
    run64(2'b11);
    rd_chk("R8 hi still no wrap", 3'd4, 16'h03A1);
  endtask

  task automatic t_cap_single();
    logic [15:0] d;
    wr(3'd0, 16'd0);
    wr(3'd3, 16'hBEEF); wr(3'd5, 16'h0); wr(3'd6, 16'h0);
    cap_pin_lo = 1;
    @(negedge clk); @(negedge clk);
    rd(3'd5, d); chk("R9 not yet after two edges", d, 16'h0);
    @(negedge clk);
    rd(3'd5, d); chk("R9 captured on third edge", d, 16'hBEEF);
    rd_chk("R9 other capture untouched", 3'd6, 16'h0);
    cap_pin_lo = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_cap_pair();
    logic [15:0] lo, hi;
    for (int d = 0; d < 20; d++) begin
      wr(3'd1, 16'd0); wr(3'd2, 16'd7);
      wr(3'd3, 16'hFFF0); wr(3'd4, 16'h03A1);
      wr(3'd0, 16'h3);
      repeat (d) @(negedge clk);
      cap_pin_lo = 1; cap_pin_hi = 1;
      repeat (4) @(negedge clk);
      wr(3'd0, 16'h0);
      cap_pin_lo = 0; cap_pin_hi = 0;
      repeat (4) @(negedge clk);
      rd(3'd5, lo); rd(3'd6, hi);
      chk($sformatf("R10 coherent d=%0d", d), hi,
          (lo >= 16'hFFF0) ? 16'h03A1 : 16'h03A2);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_regs();
    t_start();
    t_div();
    t_noclk();
    t_down();
    t_chain();
    t_cap_single();
    t_cap_pair();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule